// File: doc/BRIEF.md
# Remote Release-Sync Responder

This block sits on a processor that another processor has asked to publish its pending stores. A request arrives as a point-to-point message naming the asking processor. The responder answers by holding back every new memory operation on its own core until the local store queue reports that nothing is outstanding. At that point all earlier writes are ordered with respect to the rest of the system. It then raises a broadcast carrying its own processor number, which tells every processor, including itself, to bump the release counter kept for this processor. The asking processor treats the arrival of that broadcast as the end of its pending conditional ordering instruction.

Requests that arrive while a drain or broadcast is already under way need no extra work: the single fence already in progress covers them, so they are folded into it and produce no second broadcast. The block also keeps the local mirror of the whole release-counter vector. Broadcasts from other processors advance their entries. The entry for this processor advances only when its own broadcast is accepted, never on ordinary lock releases and never when its own broadcast comes back from the fabric. A registered read port returns any entry.

Top module: `remote_sync_responder`

## Requirements
- R1: After reset `mem_stall` and `bc_valid` are 0 and every mirror counter reads 0.
- R2: A request accepted while idle sets `mem_stall` from the next cycle. `mem_stall` stays 1 until the broadcast is accepted.
- R3: While `sq_count` is non-zero no broadcast is raised. `bc_valid` rises in the cycle after the first clock edge at which `sq_count` is sampled as 0.
- R4: If `sq_count` is 0 in the cycle a request is accepted, `bc_valid` is 1 in the very next cycle, with no drain wait.
- R5: `bc_valid` stays 1 and `bc_id` equals the parameter SELF_ID until `bc_ready` is sampled high. In the cycle after that handshake, `bc_valid` and `mem_stall` are both 0.
- R6: Requests that arrive while the responder is not idle are merged into the current operation and cause no further broadcast. This includes the cycle in which the broadcast is accepted.
- R7: The mirror entry for SELF_ID increases by exactly 1 (modulo 2^CNT_W) on each accepted own broadcast, and changes at no other time.
- R8: An incoming broadcast (`bin_valid`) whose `bin_id` is below NPROC and differs from SELF_ID increments that entry by 1 (modulo 2^CNT_W). An incoming broadcast with `bin_id` equal to SELF_ID leaves every entry unchanged.
- R9: A request whose `req_src` equals SELF_ID is ignored: `mem_stall` stays 0 and no broadcast is raised.
- R10: `rd_ctr` shows mirror entry `rd_idx` as it stood just before the clock edge, one cycle after `rd_idx` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Remote-sync request present this cycle |
| req_src | input | ID_W | Processor number of the requester |
| sq_count | input | SQ_W | Outstanding store count from the local store queue |
| mem_stall | output | 1 | Blocks issue of new memory operations |
| bc_valid | output | 1 | Counter-increment broadcast offered to the fabric |
| bc_ready | input | 1 | Fabric accepts the broadcast |
| bc_id | output | ID_W | Processor number carried by the broadcast (SELF_ID) |
| bin_valid | input | 1 | Broadcast received from the fabric |
| bin_id | input | ID_W | Processor number carried by the received broadcast |
| rd_idx | input | ID_W | Mirror entry to read |
| rd_ctr | output | CNT_W | Registered mirror entry value |
| own_ctr | output | CNT_W | Current mirror entry for SELF_ID |

## Verification
Each result has a fixed due cycle. `mem_stall` is due one edge after the request. `bc_valid` is due one edge after the request when the store queue is empty, and otherwise one edge after `sq_count` is first sampled as 0. Both drop one edge after the `bc_ready` handshake. A mirror entry changes one edge after the event that moves it, and `rd_ctr` shows it one further edge later. The bench drives inputs 1 ns after a rising edge and samples outputs before the next edge, so every check reads exactly the cycle these counts predict. The bench sweeps requester number, drain length, ready delay and merged requests over a four-processor configuration, and tracks the expected counters arithmetically.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRAIN = 2'd1,
    RS_SEND  = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rsr_req_gate.sv
module rsr_req_gate #(
  parameter int NPROC   = 4,
  parameter int SELF_ID = 0,
  localparam int ID_W   = $clog2(NPROC)
) (
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_src,
  output logic            req_hit
);
  localparam logic [ID_W:0]   NPROC_W = (ID_W+1)'(NPROC);
  localparam logic [ID_W-1:0] SELF_W  = ID_W'(SELF_ID);

  // a request from this processor itself never needs a remote fence
  assign req_hit = req_valid && (req_src != SELF_W) && ({1'b0, req_src} < NPROC_W);
endmodule

// File: rtl/rsr_fsm.sv
module rsr_fsm
  import rsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_hit,
  input  logic drained,
  input  logic bc_ready,
  output logic mem_stall,
  output logic bc_valid,
  output logic bc_fire
);
  rs_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_IDLE;
      mem_stall <= 1'b0;
      bc_valid  <= 1'b0;
    end else begin
      case (state)
        RS_IDLE: begin
          if (req_hit) begin
            mem_stall <= 1'b1;
            if (drained) begin
              state    <= RS_SEND;
              bc_valid <= 1'b1;
            end else begin
              state <= RS_DRAIN;
            end
          end
        end
        RS_DRAIN: begin
          // later requests are covered by this drain; no action needed
          if (drained) begin
            state    <= RS_SEND;
            bc_valid <= 1'b1;
          end
        end
        RS_SEND: begin
          if (bc_ready) begin
            state     <= RS_IDLE;
            bc_valid  <= 1'b0;
            mem_stall <= 1'b0;
          end
        end
        default: begin
          state     <= RS_IDLE;
          bc_valid  <= 1'b0;
          mem_stall <= 1'b0;
        end
      endcase
    end
  end

  assign bc_fire = bc_valid && bc_ready;
endmodule

// File: rtl/rsr_mirror.sv
module rsr_mirror #(
  parameter int NPROC   = 4,
  parameter int SELF_ID = 0,
  parameter int CNT_W   = 8,
  localparam int ID_W   = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             own_inc,
  input  logic             ext_valid,
  input  logic [ID_W-1:0]  ext_id,
  input  logic [ID_W-1:0]  rd_idx,
  output logic [CNT_W-1:0] rd_ctr,
  output logic [CNT_W-1:0] own_ctr
);
  localparam logic [ID_W:0] NPROC_W = (ID_W+1)'(NPROC);

  logic [CNT_W-1:0] cnt [NPROC];
  logic             ext_hit;

  assign ext_hit = ext_valid && ({1'b0, ext_id} < NPROC_W);

  for (genvar i = 0; i < NPROC; i++) begin : g_ent
    if (i == SELF_ID) begin : g_own
      // own entry: only the local broadcast moves it; the echo is dropped
      always_ff @(posedge clk) begin
        if (rst)          cnt[i] <= '0;
        else if (own_inc) cnt[i] <= cnt[i] + 1'b1;
      end
    end else begin : g_peer
      always_ff @(posedge clk) begin
        if (rst)                                  cnt[i] <= '0;
        else if (ext_hit && ext_id == ID_W'(i))   cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               rd_ctr <= '0;
    else if ({1'b0, rd_idx} < NPROC_W)     rd_ctr <= cnt[rd_idx];
    else                                   rd_ctr <= '0;
  end

  assign own_ctr = cnt[SELF_ID];
endmodule

// File: rtl/remote_sync_responder.sv
module remote_sync_responder #(
  parameter int NPROC   = 4,
  parameter int SELF_ID = 0,
  parameter int CNT_W   = 8,
  parameter int SQ_W    = 6,
  localparam int ID_W   = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ID_W-1:0]  req_src,
  input  logic [SQ_W-1:0]  sq_count,
  output logic             mem_stall,
  output logic             bc_valid,
  input  logic             bc_ready,
  output logic [ID_W-1:0]  bc_id,
  input  logic             bin_valid,
  input  logic [ID_W-1:0]  bin_id,
  input  logic [ID_W-1:0]  rd_idx,
  output logic [CNT_W-1:0] rd_ctr,
  output logic [CNT_W-1:0] own_ctr
);
  logic req_hit;
  logic drained;
  logic bc_fire;

  assign drained = (sq_count == '0);
  assign bc_id   = ID_W'(SELF_ID);

  rsr_req_gate #(.NPROC(NPROC), .SELF_ID(SELF_ID)) u_gate (
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_hit   (req_hit)
  );

  rsr_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_hit   (req_hit),
    .drained   (drained),
    .bc_ready  (bc_ready),
    .mem_stall (mem_stall),
    .bc_valid  (bc_valid),
    .bc_fire   (bc_fire)
  );

  rsr_mirror #(.NPROC(NPROC), .SELF_ID(SELF_ID), .CNT_W(CNT_W)) u_mirror (
    .clk       (clk),
    .rst       (rst),
    .own_inc   (bc_fire),
    .ext_valid (bin_valid),
    .ext_id    (bin_id),
    .rd_idx    (rd_idx),
    .rd_ctr    (rd_ctr),
    .own_ctr   (own_ctr)
  );
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker #(
  parameter int NPROC   = 4,
  parameter int SELF_ID = 0,
  parameter int CNT_W   = 8,
  parameter int SQ_W    = 6,
  localparam int ID_W   = $clog2(NPROC)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [ID_W-1:0]  req_src,
  input logic [SQ_W-1:0]  sq_count,
  input logic             mem_stall,
  input logic             bc_valid,
  input logic             bc_ready,
  input logic [ID_W-1:0]  bc_id,
  input logic [CNT_W-1:0] own_ctr
);
  localparam logic [ID_W:0]   NPROC_W = (ID_W+1)'(NPROC);
  localparam logic [ID_W-1:0] SELF_W  = ID_W'(SELF_ID);

  AST_STALL_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (!mem_stall && req_valid && req_src != SELF_W && {1'b0, req_src} < NPROC_W) |=> mem_stall); // R2
  AST_BC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    $rose(bc_valid) |-> ($past(sq_count) == '0)); // R3
  AST_BC_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> mem_stall); // R2
  AST_BC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !bc_ready) |=> bc_valid); // R5
  AST_BC_ID: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> (bc_id == SELF_W)); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_ready) |=> (!bc_valid && !mem_stall)); // R5
  AST_MERGE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_ready && req_valid) |=> !mem_stall); // R6
  AST_SELF_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!mem_stall && req_valid && req_src == SELF_W) |=> !mem_stall); // R9
  AST_OWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && bc_ready) |=> (own_ctr == CNT_W'($past(own_ctr) + 1'b1))); // R7
  AST_OWN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bc_valid && bc_ready) |=> $stable(own_ctr)); // R7
endmodule

bind remote_sync_responder rsr_checker #(
  .NPROC(NPROC), .SELF_ID(SELF_ID), .CNT_W(CNT_W), .SQ_W(SQ_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_src   (req_src),
  .sq_count  (sq_count),
  .mem_stall (mem_stall),
  .bc_valid  (bc_valid),
  .bc_ready  (bc_ready),
  .bc_id     (bc_id),
  .own_ctr   (own_ctr)
);

// File: tb/tb_remote_sync_responder.sv
`timescale 1ns/100ps
module tb_remote_sync_responder;
  localparam int NPROC = 4;
  localparam int SELF  = 2;
  localparam int CW    = 4;
  localparam int SW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_src = '0;
  logic [SW-1:0] sq_count = '0;
  logic          mem_stall, bc_valid;
  logic          bc_ready = 1'b0;
  logic [1:0]    bc_id;
  logic          bin_valid = 1'b0;
  logic [1:0]    bin_id = '0;
  logic [1:0]    rd_idx = '0;
  logic [CW-1:0] rd_ctr, own_ctr;

  int nchk = 0;
  int nfail = 0;
  int exp_c [NPROC];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  remote_sync_responder #(.NPROC(NPROC), .SELF_ID(SELF), .CNT_W(CW), .SQ_W(SW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .sq_count(sq_count),
    .mem_stall(mem_stall), .bc_valid(bc_valid), .bc_ready(bc_ready), .bc_id(bc_id),
    .bin_valid(bin_valid), .bin_id(bin_id), .rd_idx(rd_idx), .rd_ctr(rd_ctr), .own_ctr(own_ctr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic read_ent(input int idx, input string rq);
    rd_idx = 2'(idx);
    tick();
    check(int'(rd_ctr) == exp_c[idx], rq, int'(rd_ctr), exp_c[idx]);
  endtask

  // one remote-sync round: request, drain of 'drain' cycles, 'rdly' cycles before ready
  task automatic do_sync(input int src, input int drain, input int rdly, input bit extra);
    int other;
    other = (src == 0) ? 1 : 0;
    rd_idx    = 2'(SELF);
    req_valid = 1'b1;
    req_src   = 2'(src);
    sq_count  = SW'(drain);
    tick();
    req_valid = 1'b0;
    check(mem_stall == 1'b1, "R2 stall after request", int'(mem_stall), 1);
    if (drain == 0)
      check(bc_valid == 1'b1, "R4 immediate broadcast", int'(bc_valid), 1);
    for (int i = 0; i < drain; i++) begin
      check(bc_valid == 1'b0, "R3 no broadcast while draining", int'(bc_valid), 0);
      check(mem_stall == 1'b1, "R2 stall during drain", int'(mem_stall), 1);
      check(int'(rd_ctr) == exp_c[SELF], "R7 own counter steady in drain", int'(rd_ctr), exp_c[SELF]);
      if (extra && i == 0) begin
        req_valid = 1'b1;
        req_src   = 2'(other);
      end
      sq_count = (i == drain - 1) ? '0 : SW'(drain - 1 - i);
      tick();
      req_valid = 1'b0;
    end
    check(bc_valid == 1'b1, "R3 broadcast after drain", int'(bc_valid), 1);
    for (int j = 0; j < rdly; j++) begin
      check(bc_valid == 1'b1, "R5 broadcast held", int'(bc_valid), 1);
      check(int'(bc_id) == SELF, "R5 broadcast id", int'(bc_id), SELF);
      check(mem_stall == 1'b1, "R2 stall held", int'(mem_stall), 1);
      if (extra && j == 0) begin
        req_valid = 1'b1;
        req_src   = 2'(other);
      end
      tick();
      req_valid = 1'b0;
    end
    bc_ready  = 1'b1;
    bin_valid = 1'b1;
    bin_id    = extra ? 2'(src) : 2'(SELF);
    if (extra) req_valid = 1'b1;
    req_src   = 2'(other);
    tick();
    bc_ready  = 1'b0;
    bin_valid = 1'b0;
    req_valid = 1'b0;
    exp_c[SELF] = (exp_c[SELF] + 1) % (1 << CW);
    if (extra) exp_c[src] = (exp_c[src] + 1) % (1 << CW);
    check(bc_valid == 1'b0, "R5 broadcast dropped", int'(bc_valid), 0);
    check(mem_stall == 1'b0, "R5 stall released", int'(mem_stall), 0);
    tick();
    check(mem_stall == 1'b0, "R6 merged requests start nothing", int'(mem_stall), 0);
    check(bc_valid == 1'b0, "R6 single broadcast", int'(bc_valid), 0);
    check(int'(rd_ctr) == exp_c[SELF], "R7 own counter +1", int'(rd_ctr), exp_c[SELF]);
    read_ent(src, extra ? "R8 peer entry with concurrent own broadcast" : "R8 echo of own id ignored");
  endtask

  initial begin
    for (int i = 0; i < NPROC; i++) exp_c[i] = 0;
    repeat (3) tick();
    check(mem_stall == 1'b0, "R1 reset stall", int'(mem_stall), 0);
    check(bc_valid == 1'b0, "R1 reset broadcast", int'(bc_valid), 0);
    rst = 1'b0;
    for (int i = 0; i < NPROC; i++) read_ent(i, "R1 R10 counter after reset");

    // R9: own-id request ignored
    req_valid = 1'b1;
    req_src   = 2'(SELF);
    tick();
    req_valid = 1'b0;
    check(mem_stall == 1'b0, "R9 self request no stall", int'(mem_stall), 0);
    tick();
    check(bc_valid == 1'b0, "R9 self request no broadcast", int'(bc_valid), 0);
    read_ent(SELF, "R9 self request leaves counter");

    // R8: incoming broadcasts for every id, id+1 pulses each
    for (int id = 0; id < NPROC; id++) begin
      for (int k = 0; k <= id; k++) begin
        bin_valid = 1'b1;
        bin_id    = 2'(id);
        tick();
        bin_valid = 1'b0;
        if (id != SELF) exp_c[id] = (exp_c[id] + 1) % (1 << CW);
      end
    end
    for (int id = 0; id < NPROC; id++) read_ent(id, "R8 R10 incoming broadcast counts");

    // near-exhaustive sweep; 72 rounds also wrap the 4-bit own counter (R7)
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 4; d++) begin
        for (int r = 0; r < 3; r++) begin
          for (int e = 0; e < 2; e++) begin
            do_sync((s == 2) ? 3 : s, d, r, e[0]);
          end
        end
      end
    end
    for (int id = 0; id < NPROC; id++) read_ent(id, "R7 R8 final counters");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule